// File: doc/BRIEF.md
# Reorder Buffer Issue Selector with Fence Barrier

This block is a circular reorder buffer that accepts instructions in program order, sends them to execution out of order, and retires them in order. Each slot holds a bank-access descriptor. The descriptor lists up to two source banks and one destination bank, and each of the three has its own valid bit. An internal per-bank occupancy scoreboard counts the reads and writes of instructions that have been issued but have not yet completed. An instruction may leave early, ahead of older ones that are stalled, when it touches no busy bank.

A slot can also be a fence. A fence holds a position in the buffer but never goes to an execution unit. The issue scan starts at the oldest slot and stops at the first fence that has not yet completed. Nothing at or beyond that fence can issue. When the fence becomes the oldest slot, it marks itself issued and done. It then retires on the next cycle, and the younger slots become visible to the scan.

The surrounding front end writes instructions through the allocate port. It takes one selected instruction per cycle from the issue port under a ready/valid handshake. It reports finished work by slot index on the completion port, and it watches the commit port to see slots retire.

Top module: `rob_fence_issue`

## Requirements
- R1: While reset is held and on the first cycle after it, `alloc_ready` is 1, `alloc_idx` is 0, and `iss_valid` and `cmt_valid` are 0.
- R2: Slots are filled in order at `alloc_idx`, which steps by one modulo DEPTH on each accepted allocation. `alloc_ready` is 0 whenever all DEPTH slots are occupied, and an allocation request is then dropped.
- R3: The descriptor is 12 bits with this layout: [2:0] first source bank, [3] first source valid, [6:4] second source bank, [7] second source valid, [10:8] destination bank, [11] destination valid. A slot has a hazard when one of its valid sources names a bank with an outstanding writer. It also has a hazard when its valid destination names a bank with an outstanding reader or writer. Outstanding means issued and not yet completed. `iss_acc` carries the stored descriptor of the offered slot.
- R4: `iss_valid` is 1 when at least one slot is occupied, not issued, not done, not a fence, free of hazard and not masked. `iss_idx` is then the first such slot counting from the oldest slot with wrap-around.
- R5: The first occupied, not-done fence met in scan order masks itself and every later slot from issue. Slots older than it may still issue in any order.
- R6: A fence slot never appears on the issue port. An occupied, not-done fence at the oldest position becomes issued and done on that cycle's clock edge. It is committed with `cmt_fence` set on the following cycle.
- R7: A slot is marked issued only on a cycle where `iss_valid` and `iss_ready` are both 1. While `iss_ready` is 0 the same slot stays on offer.
- R8: A completion that names a slot which is unoccupied, not issued or already done has no effect.
- R9: When the oldest slot is occupied and done, `cmt_valid` is 1 and `cmt_idx` names that slot. On that edge the slot is freed and the oldest position advances by one modulo DEPTH.
- R10: An accepted completion releases the reads and writes of the descriptor stored in the completed slot. Slots blocked by those banks become eligible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Allocation request |
| alloc_fence | input | 1 | Request is a fence |
| alloc_acc | input | 12 | Bank-access descriptor of the request |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | 3 | Slot that the next allocation fills |
| iss_valid | output | 1 | A slot is offered for issue |
| iss_ready | input | 1 | Execution side accepts the offer |
| iss_idx | output | 3 | Offered slot |
| iss_acc | output | 12 | Descriptor of the offered slot |
| cmp_valid | input | 1 | Completion strobe |
| cmp_idx | input | 3 | Slot being completed |
| cmt_valid | output | 1 | Oldest slot retires this cycle |
| cmt_idx | output | 3 | Retiring slot |
| cmt_fence | output | 1 | Retiring slot is a fence |

## Verification
The assertions assume that the completion port reports only work that was actually handed out. They also assume that any bogus completion the bench sends arrives as a plain strobe on a legal index. The stimulus keeps to this by picking most completions from the bench's own list of issued, not-done slots. The remainder uses a random index in range, which checks that stray completions are ignored. Descriptors are drawn over a narrow or wide bank range so that hazards are both common and rare. Fence density is raised in dedicated phases, and `iss_ready` is held low for stretches to keep offers pending.

// File: rtl/rob_fence_pkg.sv
package rob_fence_pkg;

    localparam int unsigned BANK_ID_W = 3;
    localparam int unsigned BANK_CNT  = 1 << BANK_ID_W;

    // Source/destination bank usage of one instruction.
    typedef struct packed {
        logic                 wr_v;
        logic [BANK_ID_W-1:0] wr_id;
        logic                 rd1_v;
        logic [BANK_ID_W-1:0] rd1_id;
        logic                 rd0_v;
        logic [BANK_ID_W-1:0] rd0_id;
    } bank_acc_t;

    localparam int unsigned ACC_W = $bits(bank_acc_t);

    // Read-after-write, write-after-read and write-after-write check.
    function automatic logic acc_hazard(
        input bank_acc_t           a,
        input logic [BANK_CNT-1:0] rd_busy,
        input logic [BANK_CNT-1:0] wr_busy
    );
        logic h;
        h = 1'b0;
        if (a.rd0_v && wr_busy[a.rd0_id]) h = 1'b1;
        if (a.rd1_v && wr_busy[a.rd1_id]) h = 1'b1;
        if (a.wr_v && (rd_busy[a.wr_id] || wr_busy[a.wr_id])) h = 1'b1;
        return h;
    endfunction

endpackage

// File: rtl/rob_bank_sb.sv
module rob_bank_sb
    import rob_fence_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                inc_en,
    input  bank_acc_t           inc_acc,
    input  logic                dec_en,
    input  bank_acc_t           dec_acc,
    output logic [BANK_CNT-1:0] rd_busy,
    output logic [BANK_CNT-1:0] wr_busy
);

    localparam int unsigned RD_CW = $clog2(2 * DEPTH + 1);
    localparam int unsigned WR_CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [BANK_CNT-1:0][RD_CW-1:0] rd_cnt;
        logic [BANK_CNT-1:0][WR_CW-1:0] wr_cnt;
    } sb_st_t;

    sb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int b = 0; b < BANK_CNT; b++) begin
            logic [RD_CW-1:0] rd_up, rd_dn;
            logic [WR_CW-1:0] wr_up, wr_dn;
            rd_up = '0;
            rd_dn = '0;
            wr_up = '0;
            wr_dn = '0;
            if (inc_en && inc_acc.rd0_v && (inc_acc.rd0_id == BANK_ID_W'(b))) rd_up = rd_up + 1'b1;
            if (inc_en && inc_acc.rd1_v && (inc_acc.rd1_id == BANK_ID_W'(b))) rd_up = rd_up + 1'b1;
            if (dec_en && dec_acc.rd0_v && (dec_acc.rd0_id == BANK_ID_W'(b))) rd_dn = rd_dn + 1'b1;
            if (dec_en && dec_acc.rd1_v && (dec_acc.rd1_id == BANK_ID_W'(b))) rd_dn = rd_dn + 1'b1;
            if (inc_en && inc_acc.wr_v && (inc_acc.wr_id == BANK_ID_W'(b))) wr_up = 1'b1;
            if (dec_en && dec_acc.wr_v && (dec_acc.wr_id == BANK_ID_W'(b))) wr_dn = 1'b1;
            st_d.rd_cnt[b] = st_q.rd_cnt[b] + rd_up - rd_dn;
            st_d.wr_cnt[b] = st_q.wr_cnt[b] + wr_up - wr_dn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar b = 0; b < BANK_CNT; b++) begin : g_busy
        assign rd_busy[b] = (st_q.rd_cnt[b] != '0);
        assign wr_busy[b] = (st_q.wr_cnt[b] != '0);
    end

endmodule

// File: rtl/rob_scan_pick.sv
module rob_scan_pick
    import rob_fence_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0]            issued,
    input  logic [DEPTH-1:0]            done,
    input  logic [DEPTH-1:0]            fence,
    input  bank_acc_t [DEPTH-1:0]       acc,
    input  logic [IDX_W-1:0]            head,
    input  logic [BANK_CNT-1:0]         rd_busy,
    input  logic [BANK_CNT-1:0]         wr_busy,
    output logic                        pick_valid,
    output logic [IDX_W-1:0]            pick_idx
);

    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] barrier;

    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        assign elig[j]    = valid[j] && !issued[j] && !done[j] && !fence[j]
                            && !acc_hazard(acc[j], rd_busy, wr_busy);
        assign barrier[j] = valid[j] && fence[j] && !done[j];
    end

    always_comb begin
        logic blocked;
        int   p;
        blocked    = 1'b0;
        pick_valid = 1'b0;
        pick_idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            p = int'(head) + i;
            if (p >= int'(DEPTH)) p = p - int'(DEPTH);
            if (barrier[p]) blocked = 1'b1;
            if (!blocked && !pick_valid && elig[p]) begin
                pick_valid = 1'b1;
                pick_idx   = IDX_W'(p);
            end
        end
    end

endmodule

// File: rtl/rob_fence_issue.sv
module rob_fence_issue
    import rob_fence_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             alloc_fence,
    input  logic [ACC_W-1:0] alloc_acc,
    output logic             alloc_ready,
    output logic [IDX_W-1:0] alloc_idx,
    output logic             iss_valid,
    input  logic             iss_ready,
    output logic [IDX_W-1:0] iss_idx,
    output logic [ACC_W-1:0] iss_acc,
    input  logic             cmp_valid,
    input  logic [IDX_W-1:0] cmp_idx,
    output logic             cmt_valid,
    output logic [IDX_W-1:0] cmt_idx,
    output logic             cmt_fence
);

    typedef struct packed {
        logic [DEPTH-1:0]      valid;
        logic [DEPTH-1:0]      issued;
        logic [DEPTH-1:0]      done;
        logic [DEPTH-1:0]      fence;
        bank_acc_t [DEPTH-1:0] acc;
        logic [IDX_W-1:0]      head;
        logic [IDX_W-1:0]      tail;
    } rob_st_t;

    rob_st_t st_d, st_q;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] v);
        return (v == IDX_W'(DEPTH - 1)) ? '0 : v + 1'b1;
    endfunction

    logic                pick_valid;
    logic [IDX_W-1:0]    pick_idx;
    logic [BANK_CNT-1:0] rd_busy, wr_busy;
    logic                iss_fire, cmp_ok, head_fence, retire, alloc_fire;

    // Observation copies for the bound checker.
    logic [DEPTH-1:0] valid_q, issued_q, done_q, fence_q;
    logic [IDX_W-1:0] head_q;
    assign valid_q  = st_q.valid;
    assign issued_q = st_q.issued;
    assign done_q   = st_q.done;
    assign fence_q  = st_q.fence;
    assign head_q   = st_q.head;

    rob_scan_pick #(.DEPTH(DEPTH)) u_pick (
        .valid      (st_q.valid),
        .issued     (st_q.issued),
        .done       (st_q.done),
        .fence      (st_q.fence),
        .acc        (st_q.acc),
        .head       (st_q.head),
        .rd_busy    (rd_busy),
        .wr_busy    (wr_busy),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    rob_bank_sb #(.DEPTH(DEPTH)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_en  (iss_fire),
        .inc_acc (st_q.acc[pick_idx]),
        .dec_en  (cmp_ok),
        .dec_acc (st_q.acc[cmp_idx]),
        .rd_busy (rd_busy),
        .wr_busy (wr_busy)
    );

    always_comb begin
        st_d       = st_q;
        iss_fire   = pick_valid && iss_ready;
        cmp_ok     = cmp_valid && st_q.valid[cmp_idx] && st_q.issued[cmp_idx]
                     && !st_q.done[cmp_idx];
        head_fence = st_q.valid[st_q.head] && st_q.fence[st_q.head] && !st_q.done[st_q.head];
        retire     = st_q.valid[st_q.head] && st_q.done[st_q.head];
        alloc_fire = alloc_valid && !st_q.valid[st_q.tail];

        if (iss_fire) st_d.issued[pick_idx] = 1'b1;
        if (cmp_ok)   st_d.done[cmp_idx]    = 1'b1;
        if (head_fence) begin
            st_d.issued[st_q.head] = 1'b1;
            st_d.done[st_q.head]   = 1'b1;
        end
        if (retire) begin
            st_d.valid[st_q.head] = 1'b0;
            st_d.head             = step(st_q.head);
        end
        if (alloc_fire) begin
            st_d.valid[st_q.tail]  = 1'b1;
            st_d.issued[st_q.tail] = 1'b0;
            st_d.done[st_q.tail]   = 1'b0;
            st_d.fence[st_q.tail]  = alloc_fence;
            st_d.acc[st_q.tail]    = bank_acc_t'(alloc_acc);
            st_d.tail              = step(st_q.tail);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign alloc_ready = !st_q.valid[st_q.tail];
    assign alloc_idx   = st_q.tail;
    assign iss_valid   = pick_valid;
    assign iss_idx     = pick_idx;
    assign iss_acc     = st_q.acc[pick_idx];
    assign cmt_valid   = retire;
    assign cmt_idx     = st_q.head;
    assign cmt_fence   = st_q.fence[st_q.head];

endmodule

// File: rtl/rob_fence_issue_chk.sv
module rob_fence_issue_chk #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_ready,
    input logic             iss_valid,
    input logic [IDX_W-1:0] iss_idx,
    input logic             cmp_valid,
    input logic [IDX_W-1:0] cmp_idx,
    input logic             cmt_valid,
    input logic [IDX_W-1:0] head_idx,
    input logic [DEPTH-1:0] valid_v,
    input logic [DEPTH-1:0] issued_v,
    input logic [DEPTH-1:0] done_v,
    input logic [DEPTH-1:0] fence_v
);

    p_full_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&valid_v) |-> !alloc_ready);

    p_issue_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (valid_v[iss_idx] && !issued_v[iss_idx] && !done_v[iss_idx]));

    p_no_fence_issue_r6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> !fence_v[iss_idx]);

    p_fence_autodone_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_v[head_idx] && fence_v[head_idx] && !done_v[head_idx])
        |=> (valid_v[$past(head_idx)] && done_v[$past(head_idx)]));

    p_bad_cmp_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && valid_v[cmp_idx] && !issued_v[cmp_idx] && !fence_v[cmp_idx])
        |=> !done_v[$past(cmp_idx)]);

    p_commit_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> (head_idx == (($past(head_idx) == IDX_W'(DEPTH - 1))
                                    ? IDX_W'(0) : $past(head_idx) + 1'b1)));

endmodule

bind rob_fence_issue rob_fence_issue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_ready (alloc_ready),
    .iss_valid   (iss_valid),
    .iss_idx     (iss_idx),
    .cmp_valid   (cmp_valid),
    .cmp_idx     (cmp_idx),
    .cmt_valid   (cmt_valid),
    .head_idx    (head_q),
    .valid_v     (valid_q),
    .issued_v    (issued_q),
    .done_v      (done_q),
    .fence_v     (fence_q)
);

// File: tb/rob_fence_issue_test.sv
`timescale 1ns/1ps
module rob_fence_issue_test;

    localparam int DEPTH = 8;
    localparam int NB    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0, alloc_fence = 1'b0;
    logic [11:0] alloc_acc = '0;
    logic        alloc_ready;
    logic [2:0]  alloc_idx;
    logic        iss_valid, iss_ready = 1'b0;
    logic [2:0]  iss_idx;
    logic [11:0] iss_acc;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_idx = '0;
    logic        cmt_valid;
    logic [2:0]  cmt_idx;
    logic        cmt_fence;

    always #2 clk = ~clk;

    rob_fence_issue #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_fence(alloc_fence), .alloc_acc(alloc_acc),
        .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
        .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_idx(iss_idx), .iss_acc(iss_acc),
        .cmp_valid(cmp_valid), .cmp_idx(cmp_idx),
        .cmt_valid(cmt_valid), .cmt_idx(cmt_idx), .cmt_fence(cmt_fence)
    );

    int nchk = 0, nfail = 0;
    bit finished = 0;

    // Reference state
    bit        m_valid[DEPTH], m_iss[DEPTH], m_done[DEPTH], m_fence[DEPTH];
    bit [11:0] m_acc[DEPTH];
    int        m_head, m_tail;
    int        m_rd[NB], m_wr[NB];
    bit        e_iv;
    int        e_idx;
    string     ph;

    task automatic chk(string tag, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic bit haz(bit [11:0] a);  // R3 layout
        bit h = 0;
        if (a[3]  && m_wr[a[2:0]]  != 0) h = 1;
        if (a[7]  && m_wr[a[6:4]]  != 0) h = 1;
        if (a[11] && (m_rd[a[10:8]] != 0 || m_wr[a[10:8]] != 0)) h = 1;
        return h;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < DEPTH; i++) begin
            m_valid[i] = 0; m_iss[i] = 0; m_done[i] = 0; m_fence[i] = 0; m_acc[i] = '0;
        end
        for (int b = 0; b < NB; b++) begin m_rd[b] = 0; m_wr[b] = 0; end
        m_head = 0; m_tail = 0;
    endtask

    task automatic count(bit [11:0] a, int d);
        if (a[3])  m_rd[a[2:0]]  += d;
        if (a[7])  m_rd[a[6:4]]  += d;
        if (a[11]) m_wr[a[10:8]] += d;
    endtask

    task automatic check_outputs();
        bit seen = 0;
        e_iv = 0; e_idx = 0;
        for (int i = 0; i < DEPTH; i++) begin
            int p = (m_head + i) % DEPTH;
            if (m_valid[p] && m_fence[p] && !m_done[p]) seen = 1;
            if (!seen && !e_iv && m_valid[p] && !m_iss[p] && !m_done[p] && !m_fence[p]
                && !haz(m_acc[p])) begin
                e_iv = 1; e_idx = p;
            end
        end
        chk("R2", "alloc_ready", int'(alloc_ready), int'(!m_valid[m_tail]));
        chk("R2", "alloc_idx", int'(alloc_idx), m_tail);
        chk(ph, "iss_valid", int'(iss_valid), int'(e_iv));
        if (e_iv) begin
            chk(ph, "iss_idx", int'(iss_idx), e_idx);
            chk("R3", "iss_acc", int'(iss_acc), int'(m_acc[e_idx]));
        end
        chk(ph == "R6" ? "R6" : "R9", "cmt_valid", int'(cmt_valid),
            int'(m_valid[m_head] && m_done[m_head]));
        if (m_valid[m_head] && m_done[m_head]) begin
            chk("R9", "cmt_idx", int'(cmt_idx), m_head);
            chk("R6", "cmt_fence", int'(cmt_fence), int'(m_fence[m_head]));
        end
    endtask

    task automatic model_step();
        int  h   = m_head;
        bit  fire = e_iv && iss_ready;
        int  ci  = int'(cmp_idx);
        bit  cok = cmp_valid && m_valid[ci] && m_iss[ci] && !m_done[ci];
        bit  hf  = m_valid[h] && m_fence[h] && !m_done[h];
        bit  ret = m_valid[h] && m_done[h];
        bit  al  = alloc_valid && !m_valid[m_tail];
        if (fire) begin m_iss[e_idx] = 1; count(m_acc[e_idx], 1); end
        if (cok)  begin m_done[ci] = 1; count(m_acc[ci], -1); end   // R10 release
        if (hf)   begin m_iss[h] = 1; m_done[h] = 1; end
        if (ret)  begin m_valid[h] = 0; m_head = (h + 1) % DEPTH; end
        if (al) begin
            m_valid[m_tail] = 1; m_iss[m_tail] = 0; m_done[m_tail] = 0;
            m_fence[m_tail] = alloc_fence; m_acc[m_tail] = alloc_acc;
            m_tail = (m_tail + 1) % DEPTH;
        end
    endtask

    task automatic drive(int alloc_pct, int fence_pct, int ready_pct, int span,
                         int cmp_pct, int bad_pct);
        int n = 0, k;
        alloc_valid = ($urandom % 100) < alloc_pct;
        alloc_fence = ($urandom % 100) < fence_pct;
        alloc_acc[2:0]  = 3'($urandom % span);
        alloc_acc[6:4]  = 3'($urandom % span);
        alloc_acc[10:8] = 3'($urandom % span);
        alloc_acc[3]  = 1'($urandom);
        alloc_acc[7]  = 1'($urandom);
        alloc_acc[11] = 1'($urandom);
        iss_ready = ($urandom % 100) < ready_pct;
        cmp_valid = 0;
        cmp_idx   = '0;
        if (($urandom % 100) < bad_pct) begin
            cmp_valid = 1;                       // R8: possibly bogus target
            cmp_idx   = 3'($urandom % DEPTH);
        end else if (($urandom % 100) < cmp_pct) begin
            for (int i = 0; i < DEPTH; i++) if (m_valid[i] && m_iss[i] && !m_done[i]) n++;
            if (n > 0) begin
                k = $urandom % n;
                for (int i = 0; i < DEPTH; i++)
                    if (m_valid[i] && m_iss[i] && !m_done[i]) begin
                        if (k == 0) begin cmp_valid = 1; cmp_idx = 3'(i); end
                        k--;
                    end
            end
        end
    endtask

    task automatic run_phase(string tag, int cycles, int alloc_pct, int fence_pct,
                             int ready_pct, int span, int cmp_pct, int bad_pct);
        ph = tag;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check_outputs();
            drive(alloc_pct, fence_pct, ready_pct, span, cmp_pct, bad_pct);
            model_step();
        end
    endtask

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        ph = "R1";
        repeat (3) @(negedge clk);
        chk("R1", "alloc_ready in reset", int'(alloc_ready), 1);
        chk("R1", "alloc_idx in reset", int'(alloc_idx), 0);
        chk("R1", "iss_valid in reset", int'(iss_valid), 0);
        chk("R1", "cmt_valid in reset", int'(cmt_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "alloc_ready after reset", int'(alloc_ready), 1);
        chk("R1", "iss_valid after reset", int'(iss_valid), 0);
        // R2: fill with no issue and no completion; extra requests are dropped.
        run_phase("R2", 14, 100, 0, 0, 8, 0, 0);
        chk("R2", "full stall", int'(alloc_ready), 0);
        // R7: offers held while ready mostly low.
        run_phase("R7", 40, 60, 0, 20, 8, 50, 0);
        // R5: frequent fences bound the scan window.
        run_phase("R5", 120, 70, 25, 80, 8, 60, 0);
        // R6: dense fences reach the head and self-complete.
        run_phase("R6", 120, 70, 50, 80, 8, 60, 0);
        // R8: stray completions.
        run_phase("R8", 150, 60, 10, 70, 8, 40, 50);
        // R10: narrow bank range, many hazards released by completions.
        run_phase("R10", 300, 70, 5, 80, 2, 50, 0);
        // R4: general mix.
        run_phase("R4", 3000, 60, 8, 75, 8, 45, 5);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog run did not end actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule